// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block collects up to 63 level-sensitive interrupt request lines and decides which one the processor should take next. Each request belongs to one of seven interrupt levels. Inside a level, requests are ordered by a 3-bit rank code. Lines 1 to 7 are hard-wired: line n sits on level n, at a fixed rank in the middle of the programmable codes. Lines 8 to 63 get their level and rank from a small configuration port. Any line can be masked through that same port.

The controller drives the processor with a 3-bit code. The code is the highest level that holds an eligible pending request, provided that level is above the processor's current mask; otherwise the code is zero. The processor acknowledges a level with a one-cycle strobe. The controller answers that strobe by itself, one cycle later, without touching the peripheral. It returns 64 plus the number of the winning line, or a spurious vector of 24 when nothing is pending at the requested level. A request stays live only while its input line is high, so the peripheral must drop the line from its service routine.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, irq_lvl_o is 0, iack_vld is 0, programmable lines read back as all zeros (level 0, rank 0, unmasked), and fixed lines are unmasked.
- R2: A configuration word has bit 6 = mask, bits 5:3 = level and bits 2:0 = in-level rank. A write to address a (1 to 63) takes effect at the next clock edge. cfg_rdata shows the word of cfg_addr combinationally. For addresses 1 to 7, only the mask bit is stored, and the word reads back as level a and rank 0. Address 0 ignores writes and reads as 0.
- R3: Fixed line n (1 to 7) requests at level n.
- R4: A programmable line whose level field is 0 never wins and never raises irq_lvl_o.
- R5: A line whose mask bit is 1 is excluded from arbitration, for fixed and programmable lines alike.
- R6: One clock after the inputs are sampled, irq_lvl_o equals the highest level with an eligible pending line if that level is greater than cpu_mask, and 0 otherwise.
- R7: Within a level, the order from first to last is: rank codes 7, 6, 5, 4, then any fixed line, then rank codes 3, 2, 1, 0.
- R8: Two programmable lines with equal level and equal rank are resolved in favour of the lower-numbered line.
- R9: A cycle with iack_req high makes iack_vld high for exactly the following cycle. In that cycle iack_vec is 64 plus the winner at iack_lvl, taken from the requests present at the acknowledge edge.
- R10: When no eligible line is pending at the acknowledged level (including level 0), iack_vec is 24.
- R11: iack_vec is always 24 or in 64 to 127. Input bit 0 of irq_i is never a source.
- R12: Requests are not latched: a line that goes low stops counting from the next sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 64 | Request lines, bit n is line n, bit 0 unused |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Line number addressed by the configuration port |
| cfg_wdata | input | 7 | Configuration word to write {mask, level, rank} |
| cfg_rdata | output | 7 | Configuration word at cfg_addr |
| cpu_mask | input | 3 | Processor's current interrupt mask level |
| irq_lvl_o | output | 3 | Level code presented to the processor, 0 = none |
| iack_req | input | 1 | Acknowledge strobe |
| iack_lvl | input | 3 | Level being acknowledged |
| iack_vld | output | 1 | Acknowledge answer valid |
| iack_vec | output | 8 | Returned vector number |

## Verification
The sweeps target the points where a wrong implementation would still look reasonable:
- **Fixed-rank slot.** Every programmable rank is raced against the fixed line of the same level. A design that sorted fixed lines at the top or bottom of a level would return the wrong vector for half the rank codes.
- **Mask comparison.** The cpu_mask sweep runs from 0 to 7 for each fixed level. An off-by-one comparison (greater-or-equal instead of strictly greater) would present a level the processor already masks.
- **Equal-rank ties.** Equal-rank pairs check that the lower line number wins.
- **Ignored lines.** Disabled, masked and bit-0 lines are checked to stay invisible, both on irq_lvl_o and in the vector.
- **Empty-level acknowledge.** An acknowledge at an empty level must return 24 rather than a stale or zero vector.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int LVL_W  = 3;
  localparam int PRI_W  = 3;
  localparam int RANK_W = PRI_W + 1;

  typedef struct packed {
    logic             msk;
    logic [LVL_W-1:0] lvl;
    logic [PRI_W-1:0] pri;
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);

  // fixed lines rank between code 4 (mapped to 5) and code 3 (mapped to 3)
  localparam logic [RANK_W-1:0] FIX_RANK = RANK_W'(1 << (PRI_W - 1));

  function automatic logic [RANK_W-1:0] prog_rank(input logic [PRI_W-1:0] p);
    if (p[PRI_W-1]) return {1'b0, p} + RANK_W'(1);
    else            return {1'b0, p};
  endfunction
endpackage

// File: rtl/lic_cfg_regs.sv
module lic_cfg_regs
  import lic_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NFIX = 8,
  localparam int AW  = $clog2(NSRC)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  src_cfg_t cfg_wdata,
  output src_cfg_t cfg_rdata,
  output src_cfg_t cfg_o [NSRC]
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == 0) begin : g_none
      assign cfg_o[i] = '0;
    end else if (i < NFIX) begin : g_fix
      logic wr_en;
      logic msk_d, msk_q;
      assign wr_en = cfg_we && (cfg_addr == AW'(i));
      always_comb begin
        msk_d = msk_q;
        if (wr_en) msk_d = cfg_wdata.msk;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) msk_q <= 1'b0;
        else        msk_q <= msk_d;
      end
      assign cfg_o[i] = {msk_q, LVL_W'(i), {PRI_W{1'b0}}};
    end else begin : g_prog
      logic     wr_en;
      src_cfg_t cfg_d, cfg_q;
      assign wr_en = cfg_we && (cfg_addr == AW'(i));
      always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d = cfg_wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
      end
      assign cfg_o[i] = cfg_q;
    end
  end

  assign cfg_rdata = cfg_o[cfg_addr];

endmodule

// File: rtl/lic_eligible.sv
module lic_eligible
  import lic_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int NFIX = 8,
  parameter int NLVL = 1 << LVL_W
) (
  input  logic [NSRC-1:0]   irq_i,
  input  src_cfg_t          cfg_i  [NSRC],
  output logic [NSRC-1:0]   elig_o,
  output logic [RANK_W-1:0] rank_o [NSRC],
  output logic [LVL_W-1:0]  lvl_o  [NSRC],
  output logic [NLVL-1:0]   lvl_hit_o
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign elig_o[i] = irq_i[i] & ~cfg_i[i].msk & (cfg_i[i].lvl != '0);
    assign lvl_o[i]  = cfg_i[i].lvl;
    if (i < NFIX) begin : g_fix
      assign rank_o[i] = FIX_RANK;
    end else begin : g_prog
      assign rank_o[i] = prog_rank(cfg_i[i].pri);
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
        if (elig_o[i] && (cfg_i[i].lvl == LVL_W'(l))) hit = 1'b1;
      end
    end
    assign lvl_hit_o[l] = hit;
  end

endmodule

// File: rtl/lic_pick.sv
module lic_pick
  import lic_pkg::*;
#(
  parameter int NSRC = 64,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]   elig_i,
  input  logic [LVL_W-1:0]  lvl_i  [NSRC],
  input  logic [RANK_W-1:0] rank_i [NSRC],
  input  logic [LVL_W-1:0]  sel_lvl,
  output logic              found_o,
  output logic [IW-1:0]     idx_o
);

  logic [RANK_W-1:0] best;

  // ascending scan with strict compare keeps the lower index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig_i[i] && (lvl_i[i] == sel_lvl) && (!found_o || (rank_i[i] > best))) begin
        found_o = 1'b1;
        best    = rank_i[i];
        idx_o   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int NSRC     = 64,
  parameter int NFIX     = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24,
  localparam int AW      = $clog2(NSRC),
  localparam int IW      = $clog2(NSRC),
  localparam int VEC_W   = 8,
  localparam int NLVL    = 1 << LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_i,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [LVL_W-1:0]  cpu_mask,
  output logic [LVL_W-1:0]  irq_lvl_o,
  input  logic              iack_req,
  input  logic [LVL_W-1:0]  iack_lvl,
  output logic              iack_vld,
  output logic [VEC_W-1:0]  iack_vec
);

  src_cfg_t          wr_word, rd_word;
  src_cfg_t          src_cfg [NSRC];
  logic [NSRC-1:0]   elig;
  logic [RANK_W-1:0] src_rank [NSRC];
  logic [LVL_W-1:0]  src_lvl  [NSRC];
  logic [NLVL-1:0]   lvl_hit;
  logic              win_found;
  logic [IW-1:0]     win_idx;

  assign wr_word   = cfg_wdata;
  assign cfg_rdata = rd_word;

  lic_cfg_regs #(.NSRC(NSRC), .NFIX(NFIX)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (wr_word),
    .cfg_rdata (rd_word),
    .cfg_o     (src_cfg)
  );

  lic_eligible #(.NSRC(NSRC), .NFIX(NFIX), .NLVL(NLVL)) u_elig (
    .irq_i     (irq_i),
    .cfg_i     (src_cfg),
    .elig_o    (elig),
    .rank_o    (src_rank),
    .lvl_o     (src_lvl),
    .lvl_hit_o (lvl_hit)
  );

  lic_pick #(.NSRC(NSRC)) u_pick (
    .elig_i  (elig),
    .lvl_i   (src_lvl),
    .rank_i  (src_rank),
    .sel_lvl (iack_lvl),
    .found_o (win_found),
    .idx_o   (win_idx)
  );

  // next state
  logic [LVL_W-1:0] top_lvl, lvl_d, lvl_q;
  logic             vld_d, vld_q;
  logic [VEC_W-1:0] vec_new, vec_d, vec_q;

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (lvl_hit[l]) top_lvl = LVL_W'(l);
    end
    lvl_d   = (top_lvl > cpu_mask) ? top_lvl : '0;
    vec_new = win_found ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : VEC_W'(SPUR_VEC);
    vld_d   = iack_req;
    vec_d   = vec_q;
    if (iack_req) vec_d = vec_new;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      vld_q <= vld_d;
      vec_q <= vec_d;
    end
  end

  assign irq_lvl_o = lvl_q;
  assign iack_vld  = vld_q;
  assign iack_vec  = vec_q;

  // assertion helpers
  logic [VEC_W-1:0] ack_off;
  logic [NSRC-1:0]  ack_oh;
  assign ack_off = vec_q - VEC_W'(VEC_BASE);
  assign ack_oh  = NSRC'(1) << ack_off[IW-1:0];

  // R6
  lvl_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl_o != '0) |-> (irq_lvl_o > $past(cpu_mask)));

  // R9
  ack_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req |=> iack_vld);

  // R9
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_req |=> !iack_vld);

  // R11
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_vld |-> ((iack_vec == VEC_W'(SPUR_VEC)) ||
                  ((iack_vec >= VEC_W'(VEC_BASE)) && (iack_vec < VEC_W'(VEC_BASE + NSRC)))));

  // R12
  ack_line_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_vld && (iack_vec != VEC_W'(SPUR_VEC))) |-> ((($past(irq_i)) & ack_oh) != '0));

endmodule

// File: tb/lvl_irq_ctrl_test.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_i;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [6:0]  cfg_wdata;
  logic [6:0]  cfg_rdata;
  logic [2:0]  cpu_mask;
  logic [2:0]  irq_lvl_o;
  logic        iack_req;
  logic [2:0]  iack_lvl;
  logic        iack_vld;
  logic [7:0]  iack_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_lvl [64];
  int m_pri [64];
  int m_msk [64];

  always #5 clk = ~clk;

  lvl_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_mask(cpu_mask), .irq_lvl_o(irq_lvl_o),
    .iack_req(iack_req), .iack_lvl(iack_lvl), .iack_vld(iack_vld), .iack_vec(iack_vec)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rank_of(input int i);
    if (i < 8) return 4;
    return (m_pri[i] >= 4) ? m_pri[i] + 1 : m_pri[i];
  endfunction

  // R7 R8 R10: expected vector at level L
  function automatic int exp_vec(input logic [63:0] pat, input int L);
    int best = -1;
    int br = -1;
    for (int i = 1; i < 64; i++) begin
      if (pat[i] && m_msk[i] == 0 && m_lvl[i] != 0 && m_lvl[i] == L && rank_of(i) > br) begin
        br = rank_of(i);
        best = i;
      end
    end
    return (best < 0) ? 24 : 64 + best;
  endfunction

  function automatic int exp_lvl(input logic [63:0] pat, input int cm);
    int top = 0;
    for (int L = 1; L < 8; L++) if (exp_vec(pat, L) != 24) top = L;
    return (top > cm) ? top : 0;
  endfunction

  task automatic cfg_write(input int a, input int w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = 7'(w);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 8) begin
      m_msk[a] = (w >> 6) & 1; m_lvl[a] = (w >> 3) & 7; m_pri[a] = w & 7;
    end else if (a >= 1) begin
      m_msk[a] = (w >> 6) & 1;
    end
  endtask

  task automatic cfg_read(input string tag, input int a, input int exp);
    @(negedge clk);
    cfg_addr = 6'(a);
    #1;
    check(tag, int'(cfg_rdata), exp);
  endtask

  task automatic run_pat(input string tag, input logic [63:0] pat, input int cm);
    @(negedge clk);
    irq_i = pat; cpu_mask = 3'(cm);
    @(negedge clk);
    check({tag, " R6 level"}, int'(irq_lvl_o), exp_lvl(pat, cm));
    for (int L = 0; L < 8; L++) begin
      iack_req = 1'b1; iack_lvl = 3'(L);
      @(negedge clk);
      iack_req = 1'b0;
      check({tag, " R9 vld"}, int'(iack_vld), 1);
      check({tag, " R9 vec"}, int'(iack_vec), exp_vec(pat, L));
    end
    @(negedge clk);
    check({tag, " R9 one-shot"}, int'(iack_vld), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr;
    for (int i = 0; i < 64; i++) begin
      m_lvl[i] = (i >= 1 && i < 8) ? i : 0; m_pri[i] = 0; m_msk[i] = 0;
    end
    rst_n = 1'b0; irq_i = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    cpu_mask = '0; iack_req = 1'b0; iack_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_lvl_o", int'(irq_lvl_o), 0);
    check("R1 iack_vld", int'(iack_vld), 0);
    cfg_read("R1 prog word", 20, 0);
    cfg_read("R1 fixed word", 5, (5 << 3));
    // R2 configuration port
    cfg_write(0, 7'h7f);
    cfg_read("R2 addr0", 0, 0);
    cfg_write(3, 7'h7f);
    cfg_read("R2 fixed mask only", 3, (1 << 6) | (3 << 3));
    cfg_write(3, 0);
    cfg_read("R2 fixed unmask", 3, (3 << 3));
    cfg_write(40, 7'b0101110);
    cfg_read("R2 prog word", 40, 7'b0101110);
    // R3 R6 fixed lines against every mask value
    for (int n = 1; n < 8; n++)
      for (int cm = 0; cm < 8; cm++)
        run_pat("R3 fixed", 64'd1 << n, cm);
    // program every line, cycling levels and ranks
    for (int s = 8; s < 64; s++) cfg_write(s, (((s % 7) + 1) << 3) | ((s / 7) % 8));
    for (int s = 8; s < 64; s++) run_pat("R7 single", 64'd1 << s, 0);
    // R7 each rank raced against the fixed line of its level
    for (int s = 8; s < 64; s++) run_pat("R7 vs fixed", (64'd1 << s) | (64'd1 << ((s % 7) + 1)), 0);
    // R8 tie on equal level and rank
    cfg_write(20, (5 << 3) | 6);
    cfg_write(30, (5 << 3) | 6);
    run_pat("R8 tie", (64'd1 << 20) | (64'd1 << 30), 0);
    @(negedge clk); irq_i = (64'd1 << 20) | (64'd1 << 30);
    iack_req = 1'b1; iack_lvl = 3'd5;
    @(negedge clk); iack_req = 1'b0;
    check("R8 lower line wins", int'(iack_vec), 64 + 20);
    // R4 disabled level
    cfg_write(33, 7'b0000111);
    run_pat("R4 disabled", 64'd1 << 33, 0);
    check("R4 no level", int'(irq_lvl_o), 0);
    // R5 masked lines
    cfg_write(45, (1 << 6) | (7 << 3) | 7);
    run_pat("R5 masked prog", 64'd1 << 45, 0);
    cfg_write(2, 7'h40);
    run_pat("R5 masked fixed", (64'd1 << 2) | (64'd1 << 45), 0);
    check("R5 level", int'(irq_lvl_o), 0);
    cfg_write(2, 0);
    // R11 bit 0 is not a source, R10 empty acknowledge
    run_pat("R11 bit0", 64'd1, 0);
    run_pat("R10 empty", 64'd0, 0);
    // R12 negated line drops out
    @(negedge clk); irq_i = 64'd1 << 7; cpu_mask = 3'd0;
    @(negedge clk); check("R12 asserted", int'(irq_lvl_o), 7);
    irq_i = '0;
    @(negedge clk); check("R12 negated", int'(irq_lvl_o), 0);
    // mixed patterns
    lfsr = 64'hACE1_2468_9BDF_1357;
    for (int k = 0; k < 150; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      run_pat("R7 mixed", lfsr & {lfsr[31:0], lfsr[63:32]}, int'(lfsr[2:0]) & 3);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule